// File: doc/BRIEF.md
# UART Interrupt Status and Enable Unit

This unit collects the event pulses of a UART's transmit and receive paths and turns them into a single interrupt request. Four events are sticky: transmit level reached, framing error, break seen and receive overrun. Once one of them arrives it is held in a status bit until software clears it by writing a one to that bit. The two receive-data conditions work differently. Receive trigger level reached and receive timeout are level inputs, and the status bits show their current values without latching them.

Software reaches the unit through a two-word register window, selected by `reg_sel`. Word 0 is the status word. Reading it returns the status bits and clears nothing. Writing it clears sticky bits and can also force the transmit interrupt to set. Word 1 is the control word, which holds three group enables. The interrupt output is the registered OR of the status bits whose group is enabled.

Top module: `uart_irq_unit`

## Requirements
- R1: After a synchronous active-low reset the sticky status bits are 0, all three enables are 0 and `irq_o` is 0.
- R2: A one-cycle pulse on `evt_tx_level`, `evt_frame_err`, `evt_break` or `evt_overrun` sets status bit 0, 3, 4 or 5 respectively. The bit is visible after the next clock edge and holds until it is cleared.
- R3: Status bit 1 always equals `rx_trig_lvl` and status bit 2 always equals `rx_tmo_lvl`. Writes to status bits 1 and 2 have no effect.
- R4: Writing a 1 to status bit 0, 3, 4 or 5 (`reg_sel`=0) clears that bit. Writing a 0 to any of these bits leaves it unchanged.
- R5: A status write with bit 6 set sets status bit 0. Status bits 6 and 7 always read 0.
- R6: If a set (an event pulse, or bit 6 for the transmit bit) and a clear hit the same bit in the same cycle, the bit ends up set.
- R7: Control bits 5, 6 and 7 (`reg_sel`=1) are the transmit, receive and error enables, and they read back as written. Control bits 0 to 4 read 0 and writes to them are ignored.
- R8: `irq_o` is registered. One cycle after a given state it equals (bit0 AND tx enable) OR ((bit1 OR bit2) AND rx enable) OR ((bit3 OR bit4 OR bit5) AND error enable), evaluated on that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_tx_level | input | 1 | Transmit level reached pulse |
| evt_frame_err | input | 1 | Framing error pulse |
| evt_break | input | 1 | Break detected pulse |
| evt_overrun | input | 1 | Receive overrun pulse |
| rx_trig_lvl | input | 1 | Receive fill at or above trigger (level) |
| rx_tmo_lvl | input | 1 | Receive timeout pending (level) |
| reg_sel | input | 1 | Register select: 0 status, 1 control |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected word |
| irq_o | output | 1 | Combined interrupt request |

## Verification
A set and a clear can land on the same sticky bit in the same cycle. This happens when an event pulse coincides with a write-one-to-clear, and for the transmit bit also when a single write carries both the clear bit and the force bit. The bench provokes this with directed cycles on each latched source. It also leaves the random stimulus free to overlap pulses and writes. In every case the bench judges the result against a reference model in which the set wins. The second overlap is a status change in the same cycle as an enable write. The bench checks that `irq_o` follows the state from before that edge.

// File: rtl/uart_irq_pkg.sv
// Package: shared bit positions and widths for the UART interrupt unit.
// Assumes an 8-bit register window with a status word and a control word.
package uart_irq_pkg;
    localparam int REG_W     = 8;
    localparam int STAT_W    = 6;
    localparam int LATCH_N   = 4;
    localparam int GRP_N     = 3;
    // status word bit positions
    localparam int ST_TX     = 0;
    localparam int ST_RXTRIG = 1;
    localparam int ST_RXTMO  = 2;
    localparam int ST_FRAME  = 3;
    localparam int ST_BREAK  = 4;
    localparam int ST_OVR    = 5;
    localparam int ST_FORCE  = 6;
    // control word: enables start at this bit (tx, rx, err)
    localparam int CT_EN_LO  = 5;

    // position in the status word of latched source i (tx, frame, break, overrun)
    function automatic int latch_pos(input int i);
        case (i)
            0:       return ST_TX;
            1:       return ST_FRAME;
            2:       return ST_BREAK;
            default: return ST_OVR;
        endcase
    endfunction
endpackage

// File: rtl/uart_irq_sticky.sv
// Module: one sticky status bit with set priority over clear.
// Assumes set and clear are single-cycle qualified strobes.
module uart_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    // hold the event until cleared; a coincident set wins
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    assert_set_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_o);
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_o);
    assert_bit_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(q_o));
endmodule

// File: rtl/uart_irq_enable.sv
// Module: group enable register (tx, rx, err).
// Assumes the caller passes only the enable field of the control write data.
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [GRP_N-1:0] wfield_i,
    output logic [GRP_N-1:0] en_o
);
    // capture the enable field on a control write
    always_ff @(posedge clk) begin
        if (!rst_n)
            en_o <= '0;
        else if (wr_i)
            en_o <= wfield_i;
    end

    assert_enable_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (en_o == $past(wfield_i)));
    assert_enable_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(en_o));
endmodule

// File: rtl/uart_irq_merge.sv
// Module: gates status bits by group enables and registers the combined request.
// Assumes status layout from uart_irq_pkg; adds one cycle of latency.
module uart_irq_merge
    import uart_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [STAT_W-1:0] status_i,
    input  logic [GRP_N-1:0]  en_i,
    output logic              irq_o
);
    logic [STAT_W-1:0] gmask;

    // expand the three group enables to a per-bit mask
    always_comb begin
        gmask            = '0;
        gmask[ST_TX]     = en_i[0];
        gmask[ST_RXTRIG] = en_i[1];
        gmask[ST_RXTMO]  = en_i[1];
        gmask[ST_FRAME]  = en_i[2];
        gmask[ST_BREAK]  = en_i[2];
        gmask[ST_OVR]    = en_i[2];
    end

    // register the OR of enabled status bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            irq_o <= 1'b0;
        else
            irq_o <= |(status_i & gmask);
    end

    assert_no_irq_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i == '0) |=> !irq_o);
    assert_no_irq_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_i == '0) |=> !irq_o);
endmodule

// File: rtl/uart_irq_unit.sv
// Module: UART interrupt status/enable unit, top level.
// Assumes event inputs are single-cycle pulses and rx levels are synchronous.
module uart_irq_unit
    import uart_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_tx_level,
    input  logic             evt_frame_err,
    input  logic             evt_break,
    input  logic             evt_overrun,
    input  logic             rx_trig_lvl,
    input  logic             rx_tmo_lvl,
    input  logic             reg_sel,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             irq_o
);
    logic               st_wr;
    logic               ct_wr;
    logic [LATCH_N-1:0] ev_vec;
    logic [LATCH_N-1:0] lat_q;
    logic [STAT_W-1:0]  status;
    logic [GRP_N-1:0]   en;

    // decode the write strobe into the two words
    always_comb begin
        st_wr  = reg_wr && !reg_sel;
        ct_wr  = reg_wr &&  reg_sel;
        ev_vec = {evt_overrun, evt_break, evt_frame_err, evt_tx_level};
    end

    // one sticky cell per latched source; the tx cell also takes the force bit
    for (genvar gi = 0; gi < LATCH_N; gi++) begin : g_lat
        localparam int POS = latch_pos(gi);
        logic set_s;
        if (POS == ST_TX) begin : g_force
            assign set_s = ev_vec[gi] | (st_wr & reg_wdata[ST_FORCE]);
        end else begin : g_plain
            assign set_s = ev_vec[gi];
        end
        uart_irq_sticky u_cell (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (set_s),
            .clr_i (st_wr & reg_wdata[POS]),
            .q_o   (lat_q[gi])
        );
    end

    // assemble the status word from latched and level sources
    always_comb begin
        status            = '0;
        status[ST_TX]     = lat_q[0];
        status[ST_RXTRIG] = rx_trig_lvl;
        status[ST_RXTMO]  = rx_tmo_lvl;
        status[ST_FRAME]  = lat_q[1];
        status[ST_BREAK]  = lat_q[2];
        status[ST_OVR]    = lat_q[3];
    end

    uart_irq_enable u_en (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (ct_wr),
        .wfield_i (reg_wdata[CT_EN_LO +: GRP_N]),
        .en_o     (en)
    );

    uart_irq_merge u_merge (
        .clk      (clk),
        .rst_n    (rst_n),
        .status_i (status),
        .en_i     (en),
        .irq_o    (irq_o)
    );

    // read mux for the selected word
    always_comb begin
        if (reg_sel)
            reg_rdata = {en, {CT_EN_LO{1'b0}}};
        else
            reg_rdata = {{(REG_W-STAT_W){1'b0}}, status};
    end

    assert_rx_levels_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_sel) |-> (reg_rdata[ST_RXTRIG] == rx_trig_lvl && reg_rdata[ST_RXTMO] == rx_tmo_lvl));
    assert_force_sets_tx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && reg_wdata[ST_FORCE]) |=> lat_q[0]);
endmodule

// File: tb/uart_irq_unit_tb.sv
module uart_irq_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_tx_level = 0, evt_frame_err = 0, evt_break = 0, evt_overrun = 0;
    logic       rx_trig_lvl = 0, rx_tmo_lvl = 0;
    logic       reg_sel = 0, reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq_o;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state
    logic [5:0] m_st = 0;   // latched bits only (0,3,4,5)
    logic [2:0] m_en = 0;

    always #10 clk = ~clk;

    uart_irq_unit u_dut (
        .clk(clk), .rst_n(rst_n),
        .evt_tx_level(evt_tx_level), .evt_frame_err(evt_frame_err),
        .evt_break(evt_break), .evt_overrun(evt_overrun),
        .rx_trig_lvl(rx_trig_lvl), .rx_tmo_lvl(rx_tmo_lvl),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_o(irq_o)
    );

    function automatic logic [5:0] full_status(input logic [5:0] lat, input logic t, input logic o);
        return lat | {3'b000, o, t, 1'b0};
    endfunction

    function automatic logic model_irq(input logic [5:0] s, input logic [2:0] e);
        return (s[0] & e[0]) | ((s[1] | s[2]) & e[1]) | ((s[3] | s[4] | s[5]) & e[2]);
    endfunction

    function automatic logic [5:0] model_next(input logic [5:0] lat, input logic [3:0] ev,
                                             input logic wr_st, input logic [7:0] wd);
        logic [5:0] n = lat;
        if (wr_st) n = n & ~(wd[5:0] & 6'b111001);
        n[0] = n[0] | ev[0] | (wr_st & wd[6]);
        n[3] = n[3] | ev[1];
        n[4] = n[4] | ev[2];
        n[5] = n[5] | ev[3];
        return n;
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h at %0t", req, got, exp, $time);
        end
    endtask

    // ev = {ovr, brk, fe, tx}
    task automatic step(input logic [3:0] ev, input logic t, input logic o,
                        input logic sel, input logic wr, input logic [7:0] wd, input string req);
        logic e_irq;
        logic [7:0] e_rd;
        @(negedge clk);
        {evt_overrun, evt_break, evt_frame_err, evt_tx_level} = ev;
        rx_trig_lvl = t; rx_tmo_lvl = o;
        reg_sel = sel; reg_wr = wr; reg_wdata = wd;
        e_irq = model_irq(full_status(m_st, t, o), m_en);
        m_st  = model_next(m_st, ev, wr && !sel, wd);
        if (wr && sel) m_en = wd[7:5];
        @(posedge clk);
        #1;
        e_rd = sel ? {m_en, 5'b0} : {2'b00, full_status(m_st, t, o)};
        check(req, reg_rdata, e_rd);
        check({req, " R8 irq"}, {7'b0, irq_o}, {7'b0, e_irq});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h5eed;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, both words
        step(4'b0000, 0, 0, 0, 0, 8'h00, "R1 status");
        step(4'b0000, 0, 0, 1, 0, 8'h00, "R1 control");
        // R7 enables and ignored low bits
        step(4'b0000, 0, 0, 1, 1, 8'hFF, "R7 enables");
        step(4'b0000, 0, 0, 1, 1, 8'h1F, "R7 low bits ignored");
        step(4'b0000, 0, 0, 1, 1, 8'hE0, "R7 enables back");
        // R2 each latched source
        step(4'b0001, 0, 0, 0, 0, 8'h00, "R2 tx");
        step(4'b0010, 0, 0, 0, 0, 8'h00, "R2 frame");
        step(4'b0100, 0, 0, 0, 0, 8'h00, "R2 break");
        step(4'b1000, 0, 0, 0, 0, 8'h00, "R2 overrun");
        step(4'b0000, 0, 0, 0, 0, 8'h00, "R2 hold");
        // R4 write zero leaves bits, write one clears
        step(4'b0000, 0, 0, 0, 1, 8'h00, "R4 write zero");
        step(4'b0000, 0, 0, 0, 1, 8'h08, "R4 clear frame");
        step(4'b0000, 0, 0, 0, 1, 8'h31, "R4 clear rest");
        // R3 level bits follow inputs, writes ignored
        step(4'b0000, 1, 0, 0, 1, 8'h06, "R3 trig");
        step(4'b0000, 1, 1, 0, 0, 8'h00, "R3 both");
        step(4'b0000, 0, 1, 0, 0, 8'h00, "R3 tmo");
        step(4'b0000, 0, 0, 0, 0, 8'h00, "R3 none");
        // R5 force bit sets tx, bits 6..7 read 0
        step(4'b0000, 0, 0, 0, 1, 8'hC0, "R5 force");
        step(4'b0000, 0, 0, 0, 1, 8'h01, "R5 clear");
        // R6 set wins over clear
        step(4'b0000, 0, 0, 0, 1, 8'h41, "R6 force vs clear");
        step(4'b1110, 0, 0, 0, 1, 8'h38, "R6 events vs clear");
        step(4'b0001, 0, 0, 0, 1, 8'h39, "R6 tx vs clear");
        step(4'b0000, 0, 0, 0, 1, 8'h39, "R6 cleared after");
        // R8 enable write in same cycle as event
        step(4'b1000, 0, 0, 1, 1, 8'h00, "R8 disable with event");
        step(4'b0000, 0, 0, 0, 0, 8'h00, "R8 disabled");
        step(4'b0000, 0, 0, 1, 1, 8'h80, "R8 err enable");
        step(4'b0000, 0, 0, 0, 0, 8'h00, "R8 err irq");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] ev;
            logic [7:0] wd;
            ev = 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15));
            wd = 8'($urandom);
            step(ev, 1'($urandom), 1'($urandom), 1'($urandom_range(0, 3) == 0),
                 1'($urandom), wd, "R2 R4 R5 R6 R7 random");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule